// File: doc/BRIEF.md
# CAN Controller Operating-Mode Unit

This block decides which top-level state a CAN protocol engine is in: reset, halt, sleep or operational. Software writes one mode control register. It holds a reset request, two halt request sources, a sleep request, an auto-wake enable, a halt-during-bus-off enable and a three-bit test-mode selector. The block turns those bits, together with status from the error-confinement logic, into a one-hot state and a set of mode outputs for the engine.

A halt request that arrives while the node is bus-off is handled in one of two ways, chosen by the halt-during-bus-off enable. With the enable clear, the halt waits until the recovery sequence finishes. With the enable set, the halt takes effect at once and the block pulses a strobe that forces the engine back to error-active.

In sleep, an optional auto-wake watches the synchronised receive line. A filtered dominant level clears the sleep request and returns the block to operational. The engine is enabled again only once that state has been reached, so the frame that caused the wake-up is not received.

Top module: `can_mode_ctrl`

## Requirements
- R1: While reset is asserted and after it is released, every register bit reads 0 and `state_oh` is 4'b0001 (reset) until the first clock edge after release. All test-mode outputs are low.
- R2: The register layout is: bit 0 reset request, bit 1 halt request, bit 2 sleep request, bit 3 second halt request, bit 4 auto-wake enable, bit 5 halt-during-bus-off enable, bits 8:6 test mode. The test-mode codes are 0 normal, 1 listen-only, 2 external loop self-test, 3 internal loop self-test, 4 error-counter write and 5 forced error-passive. Each nonzero legal code drives exactly its own output.
- R3: A write of test-mode code 6 or 7 leaves the stored code unchanged. The test-mode field changes only on a write made while the state is reset or halt.
- R4: Bits 4 and 5 change only on a write made while the state is reset or halt. Writes in sleep or operational leave them unchanged.
- R5: `state_oh` is one-hot: bit 0 reset, bit 1 halt, bit 2 sleep, bit 3 operational. It follows the register one clock after the write. The reset request wins over everything else. A halt request (bit 1 or bit 3) wins over a sleep request. `engine_en` is high only in operational.
- R6: With bit 5 clear, a halt request made in operational while `bus_off` is high leaves the block operational. It enters halt on the clock edge at which `recov_done` is high, without a recovery strobe.
- R7: With bit 5 set, a halt request from either halt bit made in operational during `bus_off` enters halt on the next edge. `force_eactive` is high for exactly that one cycle.
- R8: In sleep with auto-wake enabled, a dominant (0) level on `rx_in` for two consecutive synchronised samples clears the sleep bit and enters operational. A low driven before edge 1 gives operational after edge 4.
- R9: A dominant level on `rx_in` lasting a single clock cycle does not wake the block.
- R10: With auto-wake disabled, a dominant level of any length leaves the block in sleep. Only clearing the sleep bit by software leaves sleep.
- R11: If a write that sets the sleep bit falls in the same cycle as an auto-wake, the wake wins. The sleep bit reads 0 and the state becomes operational.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| wr_en | input | 1 | Register write strobe |
| wr_data | input | 9 | Register write data |
| bus_off | input | 1 | Node is bus-off (from error confinement) |
| recov_done | input | 1 | Bus-off recovery sequence finished this cycle |
| rx_in | input | 1 | Raw CAN receive line, 0 = dominant |
| cfg_q | output | 9 | Register read-back |
| state_oh | output | 4 | One-hot state: reset, halt, sleep, operational |
| engine_en | output | 1 | Protocol engine may transmit and receive |
| force_eactive | output | 1 | One-cycle strobe forcing error-active recovery |
| tm_listen | output | 1 | Listen-only mode selected |
| tm_loop_ext | output | 1 | External loop self-test selected |
| tm_loop_int | output | 1 | Internal loop self-test selected |
| tm_ecnt_wr | output | 1 | Error-counter write mode selected |
| tm_err_passive | output | 1 | Forced error-passive mode selected |

## Verification
An auto-wake and a software write to the sleep bit can fall on the same clock edge. Both try to set the next value of that bit. The bench puts the block in sleep with auto-wake on and drives `rx_in` dominant. In the exact cycle where the filter fires, it issues a register write that sets the sleep bit. After the edge, the sleep bit must read 0 and the state must be operational. The bench also sweeps all eight test-mode codes in both an open state and a locked state, and compares each result with an arithmetic expectation.

// File: rtl/can_mode_pkg.sv
// Shared layout and state encoding for the CAN operating-mode unit.
package can_mode_pkg;
    localparam int CFG_W    = 9;
    localparam int TM_W     = 3;
    localparam int TM_CODES = 6;   // legal test-mode codes 0..5

    // Register layout, LSB first: init, halt, sleep, halt2, awake, bohalt, tm[2:0]
    typedef struct packed {
        logic [TM_W-1:0] tm;
        logic            bo_halt_en;
        logic            awake_en;
        logic            halt2;
        logic            sleep;
        logic            halt;
        logic            init;
    } cfg_t;

    typedef enum logic [3:0] {
        MS_RESET = 4'b0001,
        MS_HALT  = 4'b0010,
        MS_SLEEP = 4'b0100,
        MS_OPER  = 4'b1000
    } mode_st_e;
endpackage

// File: rtl/can_mode_cfg.sv
// Mode control register with state-dependent write gating and test-mode decode.
// Assumes: cfg_open is high only in reset or halt; wake_clr is a one-cycle
// request from the state machine that overrides any software write of sleep.
module can_mode_cfg
    import can_mode_pkg::*;
(
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 wr_en,
    input  logic [CFG_W-1:0]     wr_data,
    input  logic                 cfg_open,
    input  logic                 wake_clr,
    output cfg_t                 cfg,
    output logic [TM_CODES-1:1]  tm_dec
);
    cfg_t wr_c;
    logic tm_legal;

    assign wr_c     = cfg_t'(wr_data);
    assign tm_legal = (int'(wr_c.tm) < TM_CODES);

    // Register update: request bits always writable, config bits only when open.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cfg <= '0;
        end else begin
            if (wr_en) begin
                cfg.init  <= wr_c.init;
                cfg.halt  <= wr_c.halt;
                cfg.halt2 <= wr_c.halt2;
                cfg.sleep <= wr_c.sleep;
                if (cfg_open) begin
                    cfg.awake_en   <= wr_c.awake_en;
                    cfg.bo_halt_en <= wr_c.bo_halt_en;
                    if (tm_legal) cfg.tm <= wr_c.tm;
                end
            end
            if (wake_clr) cfg.sleep <= 1'b0;
        end
    end

    // Test-mode decode: one output per nonzero legal code.
    for (genvar i = 1; i < TM_CODES; i++) begin : g_tm_dec
        assign tm_dec[i] = (int'(cfg.tm) == i);
    end

    // R3: prohibited codes never stored
    a_r3_tm_legal: assert property (@(posedge clk) disable iff (!rst_n)
        int'(cfg.tm) < TM_CODES);
    // R3 / R4: locked fields hold through writes outside reset/halt
    a_r4_cfg_locked: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && !cfg_open) |=> ($stable(cfg.awake_en) && $stable(cfg.bo_halt_en) && $stable(cfg.tm)));
    // R11: a wake clears the sleep bit even against a write
    a_r11_wake_wins: assert property (@(posedge clk) disable iff (!rst_n)
        wake_clr |=> !cfg.sleep);
endmodule

// File: rtl/can_wake_filter.sv
// Synchronises the raw receive line and flags a dominant level that persists
// for WAKE_SAMPLES consecutive synchronised samples.
// Assumes: rx_in is asynchronous, 0 is dominant; SYNC_STAGES >= 2, WAKE_SAMPLES >= 2.
module can_wake_filter #(
    parameter int SYNC_STAGES  = 2,
    parameter int WAKE_SAMPLES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic rx_in,
    output logic wake_hit
);
    localparam int CNT_W = $clog2(WAKE_SAMPLES) + 1;
    localparam logic [CNT_W-1:0] CNT_SAT = CNT_W'(WAKE_SAMPLES - 1);

    logic [SYNC_STAGES-1:0] sync_q;
    logic [CNT_W-1:0]       dom_cnt;
    logic                   rx_s;

    // Synchroniser chain, reset to recessive.
    for (genvar i = 0; i < SYNC_STAGES; i++) begin : g_sync
        always_ff @(posedge clk) begin
            if (!rst_n)      sync_q[i] <= 1'b1;
            else if (i == 0) sync_q[i] <= rx_in;
            else             sync_q[i] <= sync_q[(i > 0) ? i - 1 : 0];
        end
    end
    assign rx_s = sync_q[SYNC_STAGES-1];

    // Count earlier consecutive dominant samples, saturating.
    always_ff @(posedge clk) begin
        if (!rst_n)              dom_cnt <= '0;
        else if (rx_s)           dom_cnt <= '0;
        else if (dom_cnt != CNT_SAT) dom_cnt <= dom_cnt + 1'b1;
    end

    assign wake_hit = !rx_s && (dom_cnt == CNT_SAT);

    // R9: a hit always follows at least one earlier dominant sample
    a_r9_no_glitch: assert property (@(posedge clk) disable iff (!rst_n)
        wake_hit |-> !$past(rx_s));
endmodule

// File: rtl/can_mode_fsm.sv
// Top-level mode state machine: reset, halt, sleep, operational.
// Assumes: bus_off/recov_done are synchronous status from error confinement;
// wake_hit comes from the wake filter.
module can_mode_fsm
    import can_mode_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic       init_req,
    input  logic       halt_req,
    input  logic       halt2_req,
    input  logic       sleep_req,
    input  logic       awake_en,
    input  logic       bo_halt_en,
    input  logic       bus_off,
    input  logic       recov_done,
    input  logic       wake_hit,
    output mode_st_e   st,
    output logic       wake_clr,
    output logic       force_eactive
);
    mode_st_e nxt;
    logic     force_d;
    logic     halt_any;

    assign halt_any = halt_req || halt2_req;

    // Next-state selection with reset > halt > sleep priority.
    always_comb begin
        nxt      = st;
        force_d  = 1'b0;
        wake_clr = 1'b0;
        if (init_req) begin
            nxt = MS_RESET;
        end else begin
            case (st)
                MS_RESET: nxt = halt_any ? MS_HALT : (sleep_req ? MS_SLEEP : MS_OPER);
                MS_HALT:  if (!halt_any) nxt = sleep_req ? MS_SLEEP : MS_OPER;
                MS_SLEEP: begin
                    if (awake_en && wake_hit) begin
                        wake_clr = 1'b1;
                        nxt      = halt_any ? MS_HALT : MS_OPER;
                    end else if (!sleep_req) begin
                        nxt = halt_any ? MS_HALT : MS_OPER;
                    end
                end
                MS_OPER: begin
                    if (halt_any) begin
                        if (!bus_off) begin
                            nxt = MS_HALT;
                        end else if (bo_halt_en) begin
                            nxt     = MS_HALT;
                            force_d = 1'b1;
                        end else if (recov_done) begin
                            nxt = MS_HALT;
                        end
                    end else if (sleep_req && !bus_off) begin
                        nxt = MS_SLEEP;
                    end
                end
                default: nxt = MS_RESET;
            endcase
        end
    end

    // State and recovery strobe registers.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st            <= MS_RESET;
            force_eactive <= 1'b0;
        end else begin
            st            <= nxt;
            force_eactive <= force_d;
        end
    end

    // R5: state stays one-hot
    a_r5_onehot: assert property (@(posedge clk) disable iff (!rst_n)
        $countones(st) == 1);
    // R7: strobe only on entry to halt from bus-off
    a_r7_force_entry: assert property (@(posedge clk) disable iff (!rst_n)
        force_eactive |-> (st == MS_HALT && $past(bus_off) && $past(st) == MS_OPER));
    // R6: deferred halt waits for recovery
    a_r6_defer: assert property (@(posedge clk) disable iff (!rst_n)
        (st == MS_OPER && halt_any && bus_off && !bo_halt_en && !recov_done && !init_req)
        |=> st == MS_OPER);
    // R10: no bus-driven exit from sleep without auto-wake
    a_r10_no_wake: assert property (@(posedge clk) disable iff (!rst_n)
        (st == MS_SLEEP && !awake_en && sleep_req && !init_req) |=> st == MS_SLEEP);
endmodule

// File: rtl/can_mode_ctrl.sv
// CAN operating-mode unit top: register, wake filter and mode state machine.
// Assumes: a single clock domain except rx_in, which is synchronised inside.
module can_mode_ctrl
    import can_mode_pkg::*;
#(
    parameter int SYNC_STAGES  = 2,
    parameter int WAKE_SAMPLES = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             wr_en,
    input  logic [CFG_W-1:0] wr_data,
    input  logic             bus_off,
    input  logic             recov_done,
    input  logic             rx_in,
    output logic [CFG_W-1:0] cfg_q,
    output logic [3:0]       state_oh,
    output logic             engine_en,
    output logic             force_eactive,
    output logic             tm_listen,
    output logic             tm_loop_ext,
    output logic             tm_loop_int,
    output logic             tm_ecnt_wr,
    output logic             tm_err_passive
);
    cfg_t                cfg;
    mode_st_e            st;
    logic                wake_clr;
    logic                wake_hit;
    logic [TM_CODES-1:1] tm_dec;

    can_mode_cfg u_cfg (
        .clk      (clk),
        .rst_n    (rst_n),
        .wr_en    (wr_en),
        .wr_data  (wr_data),
        .cfg_open (st == MS_RESET || st == MS_HALT),
        .wake_clr (wake_clr),
        .cfg      (cfg),
        .tm_dec   (tm_dec)
    );

    can_wake_filter #(
        .SYNC_STAGES  (SYNC_STAGES),
        .WAKE_SAMPLES (WAKE_SAMPLES)
    ) u_wake (
        .clk      (clk),
        .rst_n    (rst_n),
        .rx_in    (rx_in),
        .wake_hit (wake_hit)
    );

    can_mode_fsm u_fsm (
        .clk           (clk),
        .rst_n         (rst_n),
        .init_req      (cfg.init),
        .halt_req      (cfg.halt),
        .halt2_req     (cfg.halt2),
        .sleep_req     (cfg.sleep),
        .awake_en      (cfg.awake_en),
        .bo_halt_en    (cfg.bo_halt_en),
        .bus_off       (bus_off),
        .recov_done    (recov_done),
        .wake_hit      (wake_hit),
        .st            (st),
        .wake_clr      (wake_clr),
        .force_eactive (force_eactive)
    );

    assign cfg_q          = cfg;
    assign state_oh       = st;
    assign engine_en      = (st == MS_OPER);
    assign tm_listen      = tm_dec[1];
    assign tm_loop_ext    = tm_dec[2];
    assign tm_loop_int    = tm_dec[3];
    assign tm_ecnt_wr     = tm_dec[4];
    assign tm_err_passive = tm_dec[5];

    // R5: engine runs only in operational
    a_r5_engine_gate: assert property (@(posedge clk) disable iff (!rst_n)
        engine_en |-> state_oh == 4'b1000);
endmodule

// File: tb/tb_can_mode_ctrl.sv
module tb_can_mode_ctrl;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       wr_en = 1'b0;
    logic [8:0] wr_data = '0;
    logic       bus_off = 1'b0;
    logic       recov_done = 1'b0;
    logic       rx_in = 1'b1;
    logic [8:0] cfg_q;
    logic [3:0] state_oh;
    logic       engine_en, force_eactive;
    logic       tm_listen, tm_loop_ext, tm_loop_int, tm_ecnt_wr, tm_err_passive;

    int nchk = 0;
    int nfail = 0;
    bit done = 0;

    localparam logic [3:0] S_RST = 4'b0001, S_HLT = 4'b0010, S_SLP = 4'b0100, S_OPR = 4'b1000;

    always #4 clk = ~clk;

    can_mode_ctrl dut (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_data(wr_data),
        .bus_off(bus_off), .recov_done(recov_done), .rx_in(rx_in),
        .cfg_q(cfg_q), .state_oh(state_oh), .engine_en(engine_en),
        .force_eactive(force_eactive), .tm_listen(tm_listen),
        .tm_loop_ext(tm_loop_ext), .tm_loop_int(tm_loop_int),
        .tm_ecnt_wr(tm_ecnt_wr), .tm_err_passive(tm_err_passive)
    );

    function automatic logic [8:0] mk(int init, int halt, int sleep, int halt2,
                                      int aw, int boh, int tm);
        logic [2:0] t = 3'(tm);
        return {t, 1'(boh), 1'(aw), 1'(halt2), 1'(sleep), 1'(halt), 1'(init)};
    endfunction

    task automatic chk(input logic [31:0] act, input logic [31:0] exp, input string req);
        nchk++;
        if (act !== exp) begin
            nfail++;
            $display("FAIL %s: actual %0h expected %0h", req, act, exp);
        end
    endtask

    task automatic step(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic wr(input logic [8:0] d);
        @(negedge clk);
        wr_en = 1'b1; wr_data = d;
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    function automatic logic [4:0] tm_vec(int code);
        logic [4:0] v = '0;
        if (code >= 1 && code <= 5) v[code-1] = 1'b1;
        return v;
    endfunction

    initial begin
        int prev;
        int exp;
        // R1: reset state
        step(3);
        chk(state_oh, S_RST, "R1 state in reset");
        chk(cfg_q, 0, "R1 register in reset");
        chk({tm_err_passive, tm_ecnt_wr, tm_loop_int, tm_loop_ext, tm_listen}, 0, "R1 test outputs");
        rst_n = 1'b1;
        step(1);
        chk(state_oh, S_OPR, "R5 reset to operational");
        chk(engine_en, 1, "R5 engine enabled");

        // R5: enter halt
        wr(mk(0,1,0,0,0,0,0));
        step(1);
        chk(state_oh, S_HLT, "R5 halt entered");
        chk(engine_en, 0, "R5 engine off in halt");

        // R2 / R3: test-mode sweep while open
        prev = 0;
        for (int c = 0; c < 8; c++) begin
            wr(mk(0,1,0,0,0,0,c));
            exp = (c < 6) ? c : prev;
            chk(cfg_q[8:6], exp, "R3 tm stored in halt");
            chk({tm_err_passive, tm_ecnt_wr, tm_loop_int, tm_loop_ext, tm_listen}, tm_vec(exp), "R2 tm decode");
            prev = exp;
        end

        // set awake=1, bohalt=0, tm=0, then leave halt
        wr(mk(0,1,0,0,1,0,0));
        wr(mk(0,0,0,0,1,0,0));
        step(1);
        chk(state_oh, S_OPR, "R5 halt released");

        // R3 / R4: locked sweep in operational
        for (int c = 0; c < 8; c++) begin
            wr(mk(0,0,0,0,0,1,c));
            chk(cfg_q[8:4], {3'd0, 1'b0, 1'b1}, "R4 locked fields in operational");
        end

        // R6: deferred halt during bus-off
        @(negedge clk) bus_off = 1'b1;
        wr(mk(0,1,0,0,1,0,0));
        step(3);
        chk(state_oh, S_OPR, "R6 halt deferred");
        recov_done = 1'b1;
        step(1);
        recov_done = 1'b0; bus_off = 1'b0;
        chk(state_oh, S_HLT, "R6 halt after recovery");
        chk(force_eactive, 0, "R6 no strobe");

        // R7: immediate halt with either source
        wr(mk(0,1,0,0,1,1,0));
        wr(mk(0,0,0,0,1,1,0));
        step(1);
        chk(cfg_q[5:4], 2'b11, "R4 config written in halt");
        for (int src = 0; src < 2; src++) begin
            @(negedge clk) bus_off = 1'b1;
            wr(src == 0 ? mk(0,1,0,0,1,1,0) : mk(0,0,0,1,1,1,0));
            step(1);
            chk(state_oh, S_HLT, "R7 immediate halt");
            chk(force_eactive, 1, "R7 strobe high");
            step(1);
            chk(force_eactive, 0, "R7 strobe one cycle");
            bus_off = 1'b0;
            wr(mk(0,0,0,0,1,1,0));
            step(1);
            chk(state_oh, S_OPR, "R7 resume");
        end

        // R8 / R9: sleep, glitch, wake
        wr(mk(0,0,1,0,1,1,0));
        step(1);
        chk(state_oh, S_SLP, "R5 sleep entered");
        chk(engine_en, 0, "R8 engine off in sleep");
        rx_in = 1'b0;
        step(1);
        rx_in = 1'b1;
        step(6);
        chk(state_oh, S_SLP, "R9 glitch ignored");
        chk(cfg_q[2], 1, "R9 sleep bit kept");
        rx_in = 1'b0;
        step(3);
        chk(state_oh, S_SLP, "R8 not yet awake");
        step(1);
        chk(state_oh, S_OPR, "R8 woken");
        chk(cfg_q[2], 0, "R8 sleep bit cleared");
        rx_in = 1'b1;
        step(3);

        // R11: wake and sleep write in same cycle
        wr(mk(0,0,1,0,1,1,0));
        step(1);
        chk(state_oh, S_SLP, "R11 sleep before race");
        rx_in = 1'b0;
        step(2);
        @(negedge clk);
        wr_en = 1'b1; wr_data = mk(0,0,1,0,1,1,0);
        @(negedge clk);
        wr_en = 1'b0;
        chk(cfg_q[2], 0, "R11 wake beats write");
        chk(state_oh, S_OPR, "R11 operational");
        rx_in = 1'b1;
        step(3);

        // R10: auto-wake disabled
        wr(mk(0,1,0,0,1,1,0));
        step(1);
        wr(mk(0,1,0,0,0,1,0));
        wr(mk(0,0,0,0,0,1,0));
        step(1);
        chk(cfg_q[4], 0, "R10 auto-wake off");
        wr(mk(0,0,1,0,0,1,0));
        step(1);
        rx_in = 1'b0;
        step(10);
        chk(state_oh, S_SLP, "R10 bus ignored");
        rx_in = 1'b1;
        wr(mk(0,0,0,0,0,1,0));
        step(1);
        chk(state_oh, S_OPR, "R10 software exit");

        // R5 / R2: reset request and config in reset
        wr(mk(1,0,0,0,0,1,0));
        step(1);
        chk(state_oh, S_RST, "R5 reset request");
        wr(mk(1,1,1,0,0,1,3));
        step(1);
        chk(state_oh, S_RST, "R5 reset wins");
        chk(tm_loop_int, 1, "R2 internal loop in reset");

        done = 1;
        $display("End of test - %0d assertions evaluated, %0d failures", nchk, nfail);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            nchk++; nfail++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("End of test - %0d assertions evaluated, %0d failures", nchk, nfail);
            $finish;
        end
    end
endmodule